// File: doc/BRIEF.md
# Dual-Limit Binning Pattern Selector

This block sorts each measurement into a bin. A single-cycle valid pulse marks each new signed sample. The block then tests that sample against two programmable pairs of limits, each pair made of a lower and an upper bound. The tests run in a fixed priority order. The first test that fails picks a programmed 4-bit pattern. When every enabled test passes, a programmed pass pattern is picked instead. The chosen pattern is registered and driven onto four output lines. Each line has its own programmable polarity.

Software programs the block through a simple write port. Through it, it sets the four limits, the four fail patterns, the pass pattern, the two pair enables, the line polarities and the binning strobe. When the binning strobe is on, the top output line no longer carries pattern bit 3. Instead it carries a pulse lasting a programmable number of cycles, which marks each fresh result for a handler downstream. A two-state machine (`ST_IDLE`, `ST_STROBE`) times that pulse. `ST_IDLE` moves to `ST_STROBE` on a valid sample while the strobe is on and the length is nonzero (transition "arm"). `ST_STROBE` reloads its count on another such sample (transition "rearm"). It returns to `ST_IDLE` when the count runs out, or when a sample arrives with the strobe off or the length zero (transition "expire").

Top module: `limit_binner`

## Requirements
- R1: Tests run in priority order: pair-1 lower, pair-1 upper, pair-2 lower, pair-2 upper. The first failing test selects its own pattern, and later failures in the same sample change nothing.
- R2: When a pair's enable is 0, both of its tests are skipped, so they can never fail.
- R3: When at least one test is enabled and no enabled test fails, the pass pattern is selected.
- R4: A lower test fails only when the sample is strictly below its limit. An upper test fails only when the sample is strictly above its limit. All comparisons are two's-complement signed, so a sample equal to a limit passes.
- R5: Bit i of a pattern (weight 2^i) drives output line bit i, for i = 0..3.
- R6: Polarity register bit i = 0 drives a true line bit as 1. Bit i = 1 inverts line i, so a true bit is driven as 0.
- R7: With the strobe enabled, output bit 3 shows the strobe state in place of pattern bit 3. Patterns 8..15 then give the same output as patterns 0..7.
- R8: Reset clears every register, both pair enables included, so the output is 0 after reset.
- R9: With the strobe enabled and length L > 0, the strobe is true for exactly L cycles, starting in the cycle the pattern updates. A length of 0 gives no strobe.
- R10: The pattern updates on the clock edge that samples the valid pulse. It then holds through any register writes until the next valid sample.
- R11: When both enables are 0, the pass pattern is selected after every sample.
- R12: Write addresses: 0..3 hold the limits (pair-1 lower, pair-1 upper, pair-2 lower, pair-2 upper). 4..7 hold the fail patterns for those tests in the same order. 8 holds the pass pattern. 9 holds the enables (bit 0 is pair 1, bit 1 is pair 2). 10 holds the polarity. 11 holds the strobe enable in bit 0. 12 holds the strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meas_vld | input | 1 | One-cycle pulse marking a new sample |
| meas_sample | input | DW | Signed measurement sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address (R12) |
| cfg_wdata | input | DW | Register write data |
| bin_out | output | NL | Output lines after polarity |

## Verification
The hardest case to reach is a sample that fails several tests at once, because only then does the priority order matter. The bench reaches it by programming a pair whose lower limit sits above its upper limit, so that many samples fail both of its tests as well as the other pair's. It then sweeps every sample value under every enable combination. Boundary equality falls out of the same sweep, since every limit value is itself one of the samples tried.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int NUM_TESTS = 4;

    typedef enum logic [3:0] {
        A_LO1      = 4'd0,
        A_HI1      = 4'd1,
        A_LO2      = 4'd2,
        A_HI2      = 4'd3,
        A_PAT_LO1  = 4'd4,
        A_PAT_HI1  = 4'd5,
        A_PAT_LO2  = 4'd6,
        A_PAT_HI2  = 4'd7,
        A_PAT_PASS = 4'd8,
        A_ENABLE   = 4'd9,
        A_POLARITY = 4'd10,
        A_STB_CTL  = 4'd11,
        A_STB_LEN  = 4'd12
    } cfg_addr_e;

    typedef enum logic {
        ST_IDLE,
        ST_STROBE
    } stb_state_e;
endpackage

// File: rtl/lb_regs.sv
module lb_regs
    import lb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NL   = 4,
    parameter int LENW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [3:0]           addr,
    input  logic [DW-1:0]        wdata,
    output logic signed [DW-1:0] lim [NUM_TESTS],
    output logic [NL-1:0]        pat [NUM_TESTS],
    output logic [NL-1:0]        pass_pat,
    output logic [1:0]           en,
    output logic [NL-1:0]        pol,
    output logic                 stb_en,
    output logic [LENW-1:0]      stb_len
);
    for (genvar g = 0; g < NUM_TESTS; g++) begin : g_test
        localparam logic [3:0] LIM_A = 4'(int'(A_LO1) + g);
        localparam logic [3:0] PAT_A = 4'(int'(A_PAT_LO1) + g);

        always_ff @(posedge clk) begin
            if (rst) begin
                lim[g] <= '0;
                pat[g] <= '0;
            end else if (we) begin
                if (addr == LIM_A) lim[g] <= wdata;
                if (addr == PAT_A) pat[g] <= wdata[NL-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_pat <= '0;
            en       <= '0;
            pol      <= '0;
            stb_en   <= 1'b0;
            stb_len  <= '0;
        end else if (we) begin
            unique case (addr)
                A_PAT_PASS: pass_pat <= wdata[NL-1:0];
                A_ENABLE:   en       <= wdata[1:0];
                A_POLARITY: pol      <= wdata[NL-1:0];
                A_STB_CTL:  stb_en   <= wdata[0];
                A_STB_LEN:  stb_len  <= wdata[LENW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lb_eval.sv
module lb_eval
    import lb_pkg::*;
#(
    parameter int DW = 16,
    parameter int NL = 4
) (
    input  logic signed [DW-1:0] sample,
    input  logic signed [DW-1:0] lim [NUM_TESTS],
    input  logic [NL-1:0]        pat [NUM_TESTS],
    input  logic [NL-1:0]        pass_pat,
    input  logic [1:0]           en,
    output logic [NL-1:0]        sel_pat
);
    logic [NUM_TESTS-1:0] fail;

    for (genvar g = 0; g < NUM_TESTS; g++) begin : g_cmp
        if (g % 2 == 0) begin : g_lower
            assign fail[g] = en[g/2] && (sample < lim[g]);
        end else begin : g_upper
            assign fail[g] = en[g/2] && (sample > lim[g]);
        end
    end

    always_comb begin
        sel_pat = pass_pat;
        for (int i = NUM_TESTS - 1; i >= 0; i--) begin
            if (fail[i]) sel_pat = pat[i];
        end
    end
endmodule

// File: rtl/lb_strobe.sv
module lb_strobe
    import lb_pkg::*;
#(
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic            enable,
    input  logic [LENW-1:0] len,
    output logic            active
);
    stb_state_e      state, state_nxt;
    logic [LENW-1:0] cnt, cnt_nxt;
    logic            arm;

    assign arm = trig && enable && (len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (arm) begin
                    state_nxt = ST_STROBE;
                    cnt_nxt   = len;
                end
            end
            ST_STROBE: begin
                if (arm) begin
                    cnt_nxt = len;
                end else if (trig || cnt == LENW'(1)) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt - LENW'(1);
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_comb begin
        active = (state == ST_STROBE);
    end
endmodule

// File: rtl/limit_binner.sv
module limit_binner
    import lb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NL   = 4,
    parameter int LENW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 meas_vld,
    input  logic signed [DW-1:0] meas_sample,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [NL-1:0]        bin_out
);
    logic signed [DW-1:0] lim [NUM_TESTS];
    logic [NL-1:0]        pat [NUM_TESTS];
    logic [NL-1:0]        pass_pat;
    logic [1:0]           en;
    logic [NL-1:0]        pol;
    logic                 stb_en;
    logic [LENW-1:0]      stb_len;
    logic [NL-1:0]        sel_pat;
    logic [NL-1:0]        pat_q;
    logic                 stb_active;
    logic [NL-1:0]        lines;

    lb_regs #(.DW(DW), .NL(NL), .LENW(LENW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .lim(lim), .pat(pat), .pass_pat(pass_pat), .en(en), .pol(pol),
        .stb_en(stb_en), .stb_len(stb_len)
    );

    lb_eval #(.DW(DW), .NL(NL)) u_eval (
        .sample(meas_sample), .lim(lim), .pat(pat), .pass_pat(pass_pat),
        .en(en), .sel_pat(sel_pat)
    );

    lb_strobe #(.LENW(LENW)) u_stb (
        .clk(clk), .rst(rst), .trig(meas_vld), .enable(stb_en), .len(stb_len),
        .active(stb_active)
    );

    always_ff @(posedge clk) begin
        if (rst)           pat_q <= '0;
        else if (meas_vld) pat_q <= sel_pat;
    end

    always_comb begin
        lines = pat_q;
        if (stb_en) lines[NL-1] = stb_active;
        bin_out = lines ^ pol;
    end
endmodule

// File: rtl/lb_checker.sv
module lb_checker
    import lb_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NL   = 4,
    parameter int LENW = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 meas_vld,
    input logic signed [DW-1:0] meas_sample,
    input logic signed [DW-1:0] lim [NUM_TESTS],
    input logic [NL-1:0]        pat [NUM_TESTS],
    input logic [NL-1:0]        pass_pat,
    input logic [1:0]           en,
    input logic [NL-1:0]        pol,
    input logic                 stb_en,
    input logic [LENW-1:0]      stb_len,
    input logic [NL-1:0]        pat_q,
    input logic                 stb_active,
    input logic [NL-1:0]        bin_out
);
    // R8: enables are off right after reset
    a_r8_enables_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en == 2'b00));

    // R10: no valid sample, no change to the held pattern
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(meas_vld)) |-> $stable(pat_q));

    // R9: strobe begins in the cycle the pattern updates
    a_r9_strobe_start: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && stb_en && stb_len != '0) |=> stb_active);

    // R1: a pair-1 lower failure always wins
    a_r1_first_fail: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && en[0] && (meas_sample < lim[0])) |=> (pat_q == $past(pat[0])));

    // R11: nothing enabled selects the pass pattern
    a_r11_none_enabled: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && en == 2'b00) |=> (pat_q == $past(pass_pat)));

    // R6: line 0 follows its polarity bit
    a_r6_line0_polarity: assert property (@(posedge clk) disable iff (rst)
        (bin_out[0] == (pat_q[0] ^ pol[0])));
endmodule

bind limit_binner lb_checker #(.DW(DW), .NL(NL), .LENW(LENW)) u_chk (
    .clk(clk), .rst(rst), .meas_vld(meas_vld), .meas_sample(meas_sample),
    .lim(lim), .pat(pat), .pass_pat(pass_pat), .en(en), .pol(pol),
    .stb_en(stb_en), .stb_len(stb_len), .pat_q(pat_q),
    .stb_active(stb_active), .bin_out(bin_out)
);

// File: tb/sim_limit_binner.sv
module sim_limit_binner;
    localparam int DW = 4;
    localparam int NL = 4;
    localparam int LENW = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 meas_vld = 1'b0;
    logic signed [DW-1:0] meas_sample = '0;
    logic                 cfg_we = 1'b0;
    logic [3:0]           cfg_addr = '0;
    logic [DW-1:0]        cfg_wdata = '0;
    logic [NL-1:0]        bin_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_lim [4];
    int m_pat [4];
    int m_pass, m_en, m_pol;

    always #2.5 clk = ~clk;

    limit_binner #(.DW(DW), .NL(NL), .LENW(LENW)) u0 (
        .clk(clk), .rst(rst), .meas_vld(meas_vld), .meas_sample(meas_sample),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bin_out(bin_out)
    );

    task automatic chk(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = DW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 4) m_lim[a] = d;
        else if (a < 8) m_pat[a-4] = d & 15;
        else if (a == 8) m_pass = d & 15;
        else if (a == 9) m_en = d & 3;
        else if (a == 10) m_pol = d & 15;
    endtask

    task automatic measure(input int s);
        @(negedge clk);
        meas_vld = 1'b1;
        meas_sample = DW'(s);
        @(negedge clk);
        meas_vld = 1'b0;
    endtask

    function automatic int expect_pat(input int s);
        if ((m_en & 1) != 0 && s < m_lim[0]) return m_pat[0];
        if ((m_en & 1) != 0 && s > m_lim[1]) return m_pat[1];
        if ((m_en & 2) != 0 && s < m_lim[2]) return m_pat[2];
        if ((m_en & 2) != 0 && s > m_lim[3]) return m_pat[3];
        return m_pass;
    endfunction

    task automatic set_limits(input int l0, input int h0, input int l1, input int h1);
        wr(0, l0); wr(1, h0); wr(2, l1); wr(3, h1);
    endtask

    task automatic sweep(input string tag);
        for (int e = 0; e < 4; e++) begin
            wr(9, e);
            for (int p = 0; p < 2; p++) begin
                wr(10, p == 0 ? 0 : 10);
                for (int s = -8; s < 8; s++) begin
                    measure(s);
                    chk(e == 0 ? {tag, " R11 R6"} : {tag, " R1 R2 R3 R4 R5 R6"},
                        int'(bin_out), expect_pat(s) ^ m_pol);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_lim[i] = 0; m_pat[i] = 0; end
        m_pass = 0; m_en = 0; m_pol = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 output after reset", int'(bin_out), 0);

        // R12 map: patterns and pass
        wr(4, 3); wr(5, 5); wr(6, 10); wr(7, 12); wr(8, 6);

        // normal limits, boundaries included in sweep (R4)
        set_limits(-3, 4, -6, 6);
        sweep("cfgA");

        // inverted pair 1: samples fail several tests at once (R1)
        set_limits(3, -2, 0, 0);
        sweep("cfgB");

        // R10: hold through writes
        wr(10, 0); wr(9, 1); set_limits(-3, 4, -6, 6);
        measure(-5);
        chk("R10 updated", int'(bin_out), 3);
        wr(8, 9); wr(0, -8); wr(9, 0);
        repeat (4) @(negedge clk);
        chk("R10 held", int'(bin_out), 3);

        // R7 R9: strobe length 3 with pass pattern 13
        wr(9, 0); wr(8, 13); wr(12, 3); wr(11, 1);
        measure(0);
        begin
            int hi_cnt = 0;
            for (int c = 0; c < 6; c++) begin
                if (bin_out[3]) hi_cnt++;
                if (c == 0) chk("R7 low bits during strobe", int'(bin_out[2:0]), 5);
                @(negedge clk);
            end
            chk("R9 strobe length 3", hi_cnt, 3);
        end
        chk("R7 pattern 13 after strobe", int'(bin_out), 5);
        wr(8, 5);
        measure(0);
        repeat (4) @(negedge clk);
        chk("R7 pattern 5 matches 13", int'(bin_out), 5);

        // R6 on strobe line: active-low line 3
        wr(10, 8);
        chk("R6 idle strobe line inverted", int'(bin_out[3]), 1);
        measure(0);
        chk("R6 R9 active strobe inverted", int'(bin_out[3]), 0);
        repeat (4) @(negedge clk);
        wr(10, 0);

        // R9: length 0 gives no strobe
        wr(12, 0);
        measure(0);
        chk("R9 zero length no strobe", int'(bin_out[3]), 0);
        @(negedge clk);
        chk("R9 zero length later", int'(bin_out[3]), 0);
        wr(11, 0);

        // R8: reset clears the enables
        wr(9, 3); set_limits(3, -2, 0, 0);
        @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
        m_en = 0; m_pol = 0;
        chk("R8 output zero after second reset", int'(bin_out), 0);
        set_limits(3, -2, 0, 0);
        wr(4, 3); wr(5, 5); wr(6, 10); wr(7, 12); wr(8, 6);
        measure(0);
        chk("R8 enables off after reset", int'(bin_out), 6);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule